// File: doc/BRIEF.md
# GPIO Port Data Register Block

This block is the data side of a 32-pin general-purpose I/O port. A small register bus, made of a write strobe, a word address, write data and combinational read data, reaches a direction register, an output data register and an input-disable mask. It also reaches a read-only view of the pin levels, which pass through a two-flop synchronizer before they can be read. Each pin drives its output value only while its direction bit selects output.

The output data register can be loaded as a whole. It can also be changed a few bits at a time through three write-only aliases: one sets bits, one clears bits and one inverts bits. Each alias takes a mask in which a 1 selects the bit, so software never needs a read-modify-write sequence and never races another writer of the same port. The bus is a plain register interface, not a stream. Every access completes in the cycle it is presented, the block never stalls, and there is no back-pressure. Reads are combinational from the address. Writes take effect at the next rising clock edge.

Register offsets (3-bit word address):
- 0: output data, read/write.
- 1: set alias.
- 2: clear alias.
- 3: toggle alias.
- 4: synchronized pin input, read-only.
- 5: direction.
- 6: input disable.
- 7: unmapped.

Top module: `gpio_port`

## Requirements
- R1: While and after the asynchronous active-low reset, the output data, direction and input-disable registers are all zero, so pin_oe is zero.
- R2: A write to offset 0 loads the output data register with wdata. Reading offset 0 returns it. With no write, the register holds its value.
- R3: A write to the set alias (offset 1) forces to 1 every output data bit whose wdata bit is 1. It leaves the other bits unchanged.
- R4: A write to the clear alias (offset 2) forces to 0 every output data bit whose wdata bit is 1. It leaves the other bits unchanged. Inside the update logic, clear takes priority over set for the same bit.
- R5: A write to the toggle alias (offset 3) inverts every output data bit whose wdata bit is 1. It leaves the other bits unchanged.
- R6: Reads of offsets 1, 2, 3 and 7 return zero.
- R7: A write to offset 5 loads the direction register, where bit value 1 means output and 0 means input. Reading offset 5 returns it, and pin_oe equals it from the cycle after the write.
- R8: pin_out carries the output data bit on pins whose direction bit is 1. It is 0 on pins whose direction bit is 0.
- R9: Reading offset 4 returns one bit per pin, 1 for a high level and 0 for a low level. The value is taken through a two-stage synchronizer, so a level presented before a rising edge is visible after the second rising edge and not after the first.
- R10: The input-disable register (offset 6, read/write) forces to 0 the offset 4 bit of every pin whose disable bit is 1. Clearing the disable bit restores the synchronized level.
- R11: Writes to offset 4 have no effect on any register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the addressed register |
| addr | input | 3 | Word address of the register |
| wdata | input | 32 | Write data or bit mask |
| rdata | output | 32 | Read data of the addressed register, combinational |
| pin_in | input | 32 | Raw pin levels, asynchronous to clk |
| pin_out | output | 32 | Output levels toward the pads |
| pin_oe | output | 32 | Per-pin output enable (direction) |

## Verification
A register write presented before a rising edge is due on rdata, pin_out and pin_oe in the low phase right after that edge. An alias or unmapped read is due in the same cycle the address is applied. A pin level is due on offset 4 only after two rising edges, and the bench checks both the stale value after one edge and the new value after two. Each check task applies its stimulus at a falling edge and queues the expected value one nanosecond later, and the monitor samples three nanoseconds after the falling edge, which is always before the next rising edge. As a result every comparison falls in exactly the cycle the result is due.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam int unsigned REG_AW = 3;

  // Word offsets of the register bus
  typedef enum logic [REG_AW-1:0] {
    OFS_DATA = 3'd0,
    OFS_SET  = 3'd1,
    OFS_CLR  = 3'd2,
    OFS_TGL  = 3'd3,
    OFS_PIN  = 3'd4,
    OFS_DIR  = 3'd5,
    OFS_IDIS = 3'd6
  } reg_ofs_e;

  // One-hot write strobes produced by the decoder
  typedef struct packed {
    logic data;
    logic set;
    logic clr;
    logic tgl;
    logic dir;
    logic idis;
  } wr_strobe_t;

endpackage

// File: rtl/gpio_reg_decode.sv
module gpio_reg_decode
  import gpio_port_pkg::*;
(
  input  logic              wr_en,
  input  logic [REG_AW-1:0] addr,
  output wr_strobe_t        stb
);

  always_comb begin
    stb = '0;
    if (wr_en) begin
      case (addr)
        OFS_DATA: stb.data = 1'b1;
        OFS_SET:  stb.set  = 1'b1;
        OFS_CLR:  stb.clr  = 1'b1;
        OFS_TGL:  stb.tgl  = 1'b1;
        OFS_DIR:  stb.dir  = 1'b1;
        OFS_IDIS: stb.idis = 1'b1;
        default:  stb = '0;  // input view and unmapped: writes dropped
      endcase
    end
  end

endmodule

// File: rtl/gpio_cfg_reg.sv
module gpio_cfg_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= d;
  end

  // R7/R10: a loaded config register shows the written value one cycle later
  assert_cfg_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (q == $past(d)));

endmodule

// File: rtl/gpio_out_reg.sv
module gpio_out_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic         set_en,
  input  logic         clr_en,
  input  logic         tgl_en,
  input  logic [W-1:0] val,
  output logic [W-1:0] q
);

  logic [W-1:0] nxt;

  // Fixed order: load, toggle, set, then clear last so clear wins
  always_comb begin
    nxt = q;
    if (load_en) nxt = val;
    if (tgl_en)  nxt = nxt ^ val;
    if (set_en)  nxt = nxt | val;
    if (clr_en)  nxt = nxt & ~val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end

  assert_set_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && !clr_en) |=> ((q & $past(val)) == $past(val)));

  assert_clr_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> ((q & $past(val)) == '0));

  assert_tgl_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tgl_en && !set_en && !clr_en && !load_en) |=> (q == ($past(q) ^ $past(val))));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_en || set_en || clr_en || tgl_en) |=> $stable(q));

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_sync
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= pin_in;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[i] <= '0;
      else        stg[i] <= stg[i-1];
    end

    assert_stage_shift_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ran |-> (stg[i] == $past(stg[i-1])));
  end

  assign pin_sync = stg[STAGES-1];

  // Marks that at least one edge has passed since reset, for the checks
  logic ran;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ran <= 1'b0;
    else        ran <= 1'b1;
  end

  assert_first_stage_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ran |-> (stg[0] == $past(pin_in)));

endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int unsigned NPINS       = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [NPINS-1:0]  wdata,
  output logic [NPINS-1:0]  rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe
);

  wr_strobe_t       stb;
  logic [NPINS-1:0] out_q;
  logic [NPINS-1:0] dir_q;
  logic [NPINS-1:0] idis_q;
  logic [NPINS-1:0] pin_sync;
  logic [NPINS-1:0] pin_view;

  gpio_reg_decode u_dec (
    .wr_en (wr_en),
    .addr  (addr),
    .stb   (stb)
  );

  gpio_out_reg #(.W(NPINS)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_en (stb.data),
    .set_en  (stb.set),
    .clr_en  (stb.clr),
    .tgl_en  (stb.tgl),
    .val     (wdata),
    .q       (out_q)
  );

  gpio_cfg_reg #(.W(NPINS)) u_dir (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (stb.dir),
    .d     (wdata),
    .q     (dir_q)
  );

  gpio_cfg_reg #(.W(NPINS)) u_idis (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (stb.idis),
    .d     (wdata),
    .q     (idis_q)
  );

  gpio_in_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_in   (pin_in),
    .pin_sync (pin_sync)
  );

  // Disabled inputs read as zero
  assign pin_view = pin_sync & ~idis_q;

  // Drive only where the direction selects output
  assign pin_oe  = dir_q;
  assign pin_out = out_q & dir_q;

  always_comb begin
    case (addr)
      OFS_DATA: rdata = out_q;
      OFS_PIN:  rdata = pin_view;
      OFS_DIR:  rdata = dir_q;
      OFS_IDIS: rdata = idis_q;
      default:  rdata = '0;  // aliases and unmapped read zero
    endcase
  end

  // R1: register state is zero right after reset is released
  assert_reset_clear_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (pin_oe == '0 && out_q == '0 && idis_q == '0));

  // R8: no pin drives a one while its output enable is off
  assert_no_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_out & ~pin_oe) == '0));

endmodule

// File: tb/tb_gpio_port.sv
`timescale 1ns/1ps
module tb_gpio_port;

  localparam int unsigned N = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [2:0]   addr = '0;
  logic [N-1:0] wdata = '0;
  logic [N-1:0] rdata;
  logic [N-1:0] pin_in = '0;
  logic [N-1:0] pin_out;
  logic [N-1:0] pin_oe;

  always #4 clk = ~clk;  // 125 MHz

  gpio_port dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  typedef struct {
    int           kind;  // 0 rdata, 1 pin_out, 2 pin_oe
    logic [N-1:0] exp;
    string        tag;
  } item_t;

  item_t q[$];
  int tests = 0;
  int fails = 0;
  bit done = 0;

  // Bench model of the registers
  logic [N-1:0] m_out = '0, m_dir = '0, m_idis = '0, m_pin = '0;

  task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    case (a)
      3'd0: m_out = d;
      3'd1: m_out = m_out | d;
      3'd2: m_out = m_out & ~d;
      3'd3: m_out = m_out ^ d;
      3'd5: m_dir = d;
      3'd6: m_idis = d;
      default: ;
    endcase
  endtask

  task automatic chk(input int kind, input logic [2:0] a,
                     input logic [N-1:0] e, input string tag);
    item_t it;
    @(negedge clk);
    wr_en = 1'b0; addr = a;
    #1;
    it.kind = kind; it.exp = e; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic set_pins(input logic [N-1:0] v);
    @(negedge clk);
    wr_en = 1'b0; pin_in = v;
  endtask

  // Monitor: samples 3 ns after the falling edge
  initial begin
    forever begin
      @(negedge clk);
      #3;
      while (q.size() > 0) begin
        item_t it;
        logic [N-1:0] act;
        it = q.pop_front();
        act = (it.kind == 0) ? rdata : (it.kind == 1) ? pin_out : pin_oe;
        tests++;
        if (act !== it.exp) begin
          fails++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk(0, 3'd0, '0, "R1 data after reset");
    chk(0, 3'd5, '0, "R1 dir after reset");
    chk(0, 3'd6, '0, "R1 idis after reset");
    chk(2, 3'd0, '0, "R1 pin_oe after reset");

    // R2 direct load and hold
    wr(3'd0, 32'hA5A5_0F0F);
    chk(0, 3'd0, m_out, "R2 data load");
    chk(0, 3'd0, m_out, "R2 data hold");

    // R3 set alias
    wr(3'd1, 32'h0000_F0F0);
    chk(0, 3'd0, m_out, "R3 set mask");
    wr(3'd1, 32'h0000_0000);
    chk(0, 3'd0, m_out, "R3 zero mask no change");

    // R4 clear alias
    wr(3'd2, 32'hFF00_000F);
    chk(0, 3'd0, m_out, "R4 clear mask");

    // R5 toggle alias
    wr(3'd3, 32'h0F0F_0F0F);
    chk(0, 3'd0, m_out, "R5 toggle mask");

    // R6 aliases and unmapped read zero
    chk(0, 3'd1, '0, "R6 set alias reads 0");
    chk(0, 3'd2, '0, "R6 clear alias reads 0");
    chk(0, 3'd3, '0, "R6 toggle alias reads 0");
    chk(0, 3'd7, '0, "R6 unmapped reads 0");

    // R7 direction
    wr(3'd5, 32'hFFFF_0000);
    chk(0, 3'd5, m_dir, "R7 dir readback");
    chk(2, 3'd0, m_dir, "R7 pin_oe follows dir");

    // R8 output gated by direction
    chk(1, 3'd0, m_out & m_dir, "R8 pin_out gated");

    // R9 two-stage synchronizer
    set_pins(32'h1234_5678);
    chk(0, 3'd4, m_pin, "R9 stale after one edge");
    m_pin = 32'h1234_5678;
    chk(0, 3'd4, m_pin, "R9 visible after two edges");

    // R10 input disable
    wr(3'd6, 32'h0000_00FF);
    chk(0, 3'd4, m_pin & ~m_idis, "R10 disabled bits read 0");
    chk(0, 3'd6, m_idis, "R10 idis readback");
    wr(3'd6, 32'h0000_0000);
    chk(0, 3'd4, m_pin, "R10 re-enabled");

    // R11 write to input view ignored
    wr(3'd4, 32'hFFFF_FFFF);
    chk(0, 3'd4, m_pin, "R11 pin view unchanged");
    chk(0, 3'd0, m_out, "R11 data unchanged");
    chk(0, 3'd5, m_dir, "R11 dir unchanged");
    chk(0, 3'd6, m_idis, "R11 idis unchanged");

    // R3/R5 end bits with a fresh pattern
    wr(3'd0, 32'h0000_0000);
    wr(3'd1, 32'h8000_0001);
    wr(3'd3, 32'h8000_0000);
    chk(0, 3'd0, m_out, "R3 R5 edge bits");
    chk(1, 3'd0, m_out & m_dir, "R8 pin_out edge bits");

    repeat (3) @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule